// File: doc/BRIEF.md
# Power-Down Wake-Up Signaller

This block owns the shared data line while a converter front end sits in power-down. The command decoder hands it a one-cycle power-down request together with a mode bit. On that request it records the current levels of the channel inputs and starts driving the data line at a resting level equal to the mode bit. It keeps watching the inputs on its own free-running clock, so the host may stop its serial clock for the whole sleep period.

A channel may wake the host only if it is configured as a digital input and its wake enable is set. The first time such a channel differs from its recorded level, the data line flips to the opposite level and stays there. Later input activity has no effect until the host raises START. START high ends power-down and releases the line to high impedance. The power-down status output stands in for the analog power gating.

Top module: `pwrdn_wake`

## Requirements
- R1: After reset the block is idle: `dio_oe`=0, `pd_active`=0, `dio_out`=0.
- R2: A `pd_req` pulse sampled while idle with `start_hi`=0 makes, at the next clock edge, `pd_active`=1, `dio_oe`=1 and `dio_out` equal to `pd_mode` (mode 0 rests at 0, mode 1 rests at 1).
- R3: While waiting, a qualifying channel whose level differs from its level recorded at entry flips `dio_out` to the inverse of the entry mode. The flip appears at the third clock edge after the input change: two synchroniser stages, then the registered compare.
- R4: A channel qualifies only when its `ch_analog` bit is 0 (digital) and its `wake_en` bit is 1. Changes on analog channels or on disabled channels leave `dio_out` at its resting level.
- R5: Once flipped, `dio_out` holds its level for as long as `start_hi` stays 0, whatever the channels do.
- R6: `start_hi`=1 sampled while powered down returns the block to idle at the next edge (`dio_oe`=0, `pd_active`=0, `dio_out`=0).
- R7: `pd_req` is ignored when `start_hi`=1 or when the block is already powered down. In the second case the resting level keeps the original mode.
- R8: With no qualifying channel, the block waits at its resting level until `start_hi` rises.
- R9: The reference for comparison is the synchronised level at entry. A channel that changed before entry and then holds steady does not trigger. Returning it to its earlier level does trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | One-cycle power-down request from the command decoder |
| pd_mode | input | 1 | Mode of the request: resting level of the data line |
| start_hi | input | 1 | Host START level, already in the `clk` domain; 1 ends power-down |
| ch_analog | input | N_CH | Per-channel type, 1 = analog, 0 = digital |
| wake_en | input | N_CH | Per-channel wake enable, 1 = enabled |
| ch_in | input | N_CH | Raw asynchronous channel levels |
| dio_out | output | 1 | Level driven on the data line |
| dio_oe | output | 1 | Data line output enable; 0 means high impedance |
| pd_active | output | 1 | Power-down status |

## Verification
The bench builds the block with eight channels and a two-stage synchroniser. Its model therefore has to place each wake flip exactly three edges after a channel toggle. Eight channels allow every mix of analog or digital with enabled or disabled in one configuration word. That makes the qualifying rule, the snapshot reference and the hold after the flip all observable on the data line in both modes.

// File: rtl/pwrdn_wake_pkg.sv
package pwrdn_wake_pkg;
  typedef enum logic [1:0] {
    PW_IDLE   = 2'd0,
    PW_WAIT   = 2'd1,
    PW_SIGNAL = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pw_sync.sv
module pw_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[g] <= '0;
      else     stage_q[g] <= stage_q[g-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pw_detect.sv
module pw_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] analog,
  input  logic [W-1:0] enable,
  output logic         hit
);
  logic [W-1:0] snap_q;
  logic [W-1:0] qual;

  always_ff @(posedge clk) begin
    if (rst)          snap_q <= '0;
    else if (capture) snap_q <= lvl;
  end

  assign qual = ~analog & enable;
  assign hit  = |((lvl ^ snap_q) & qual);
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
  import pwrdn_wake_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pd_req,
  input  logic pd_mode,
  input  logic start_hi,
  input  logic hit,
  output logic capture,
  output logic dio_out,
  output logic dio_oe,
  output logic pd_active
);
  pw_state_e state_q, state_d;
  logic      mode_q;

  assign capture = (state_q == PW_IDLE) && pd_req && !start_hi;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_IDLE:   if (capture) state_d = PW_WAIT;
      PW_WAIT:   if (start_hi) state_d = PW_IDLE;
                 else if (hit) state_d = PW_SIGNAL;
      PW_SIGNAL: if (start_hi) state_d = PW_IDLE;
      default:   state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PW_IDLE;
      mode_q    <= 1'b0;
      dio_out   <= 1'b0;
      dio_oe    <= 1'b0;
      pd_active <= 1'b0;
    end else begin
      state_q   <= state_d;
      if (capture) mode_q <= pd_mode;
      dio_oe    <= (state_d != PW_IDLE);
      pd_active <= (state_d != PW_IDLE);
      case (state_d)
        PW_WAIT:   dio_out <= capture ? pd_mode : mode_q;
        PW_SIGNAL: dio_out <= ~mode_q;
        default:   dio_out <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/pwrdn_wake.sv
module pwrdn_wake #(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pd_req,
  input  logic            pd_mode,
  input  logic            start_hi,
  input  logic [N_CH-1:0] ch_analog,
  input  logic [N_CH-1:0] wake_en,
  input  logic [N_CH-1:0] ch_in,
  output logic            dio_out,
  output logic            dio_oe,
  output logic            pd_active
);
  logic [N_CH-1:0] lvl_sync;
  logic            capture;
  logic            hit;

  pw_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ch_in), .dout(lvl_sync)
  );

  pw_detect #(.W(N_CH)) u_detect (
    .clk(clk), .rst(rst), .capture(capture), .lvl(lvl_sync),
    .analog(ch_analog), .enable(wake_en), .hit(hit)
  );

  pw_fsm u_fsm (
    .clk(clk), .rst(rst), .pd_req(pd_req), .pd_mode(pd_mode),
    .start_hi(start_hi), .hit(hit), .capture(capture),
    .dio_out(dio_out), .dio_oe(dio_oe), .pd_active(pd_active)
  );
endmodule

// File: rtl/pwrdn_wake_chk.sv
module pwrdn_wake_chk (
  input logic clk,
  input logic rst,
  input logic pd_req,
  input logic pd_mode,
  input logic start_hi,
  input logic dio_out,
  input logic dio_oe,
  input logic pd_active
);
  logic ent_mode;

  always_ff @(posedge clk) begin
    if (rst) ent_mode <= 1'b0;
    else if (!pd_active && pd_req && !start_hi) ent_mode <= pd_mode;
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (!dio_oe && !pd_active));

  p_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (!pd_active && pd_req && !start_hi) |=> (pd_active && dio_oe && dio_out == $past(pd_mode)));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pd_active && !start_hi && dio_out != ent_mode) |=> (!pd_active || $stable(dio_out)));

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    (pd_active && start_hi) |=> (!pd_active && !dio_oe));

  p_no_entry_r7: assert property (@(posedge clk) disable iff (rst)
    (!pd_active && start_hi) |=> !pd_active);

  p_oe_status_r2: assert property (@(posedge clk) disable iff (rst)
    dio_oe == pd_active);
endmodule

bind pwrdn_wake pwrdn_wake_chk u_chk (
  .clk(clk), .rst(rst), .pd_req(pd_req), .pd_mode(pd_mode),
  .start_hi(start_hi), .dio_out(dio_out), .dio_oe(dio_oe),
  .pd_active(pd_active)
);

// File: tb/test_pwrdn_wake.sv
module test_pwrdn_wake;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pd_req = 1'b0, pd_mode = 1'b0, start_hi = 1'b1;
  logic [N-1:0] ch_analog = '0, wake_en = '0, ch_in = '0;
  logic         dio_out, dio_oe, pd_active;

  int    n_chk = 0, n_fail = 0;
  string tag = "R1";
  bit    started = 0, done = 0;

  // behavioural model state
  int           m_st = 0;       // 0 idle, 1 waiting, 2 signalled
  logic [N-1:0] m_s1 = '0, m_s2 = '0, m_snap = '0;
  logic         m_mode = 0, e_dio = 0, e_oe = 0;

  always #2.5 clk = ~clk;

  pwrdn_wake #(.N_CH(N), .SYNC_STAGES(2)) i_pwrdn_wake (
    .clk(clk), .rst(rst), .pd_req(pd_req), .pd_mode(pd_mode),
    .start_hi(start_hi), .ch_analog(ch_analog), .wake_en(wake_en),
    .ch_in(ch_in), .dio_out(dio_out), .dio_oe(dio_oe), .pd_active(pd_active)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_st = 0; m_s1 = '0; m_s2 = '0; m_snap = '0; m_mode = 0;
    end else begin
      bit diff, cap;
      diff = (((m_s2 ^ m_snap) & ~ch_analog & wake_en) != '0);
      cap  = (m_st == 0) && pd_req && !start_hi;
      if (m_st == 0) begin
        if (cap) begin m_st = 1; m_snap = m_s2; m_mode = pd_mode; end
      end else if (start_hi) m_st = 0;
      else if (m_st == 1 && diff) m_st = 2;
      m_s2 = m_s1;
      m_s1 = ch_in;
    end
    e_oe  = (m_st != 0);
    e_dio = (m_st == 1) ? m_mode : (m_st == 2) ? ~m_mode : 1'b0;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (dio_oe !== e_oe || pd_active !== e_oe || dio_out !== e_dio) begin
        n_fail++;
        $display("FAIL %s: oe=%b act=%b dio=%b expected oe=%b act=%b dio=%b",
                 tag, dio_oe, pd_active, dio_out, e_oe, e_oe, e_dio);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request(logic m);
    @(negedge clk); pd_mode = m; pd_req = 1;
    @(negedge clk); pd_req = 0;
  endtask

  task automatic spot(string t, logic oe, logic d);
    n_chk++;
    if (dio_oe !== oe || dio_out !== d) begin
      n_fail++;
      $display("FAIL %s: oe=%b dio=%b expected oe=%b dio=%b", t, dio_oe, dio_out, oe, d);
    end
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    spot("R1", 1'b0, 1'b0);
    rst = 0;
    ch_analog = 8'b0000_0011;     // ch0, ch1 analog
    wake_en   = 8'b0011_1110;     // qualifying: ch2..ch5
    ch_in     = 8'hA5;
    cyc(4);

    // R7: request while START high is ignored
    tag = "R7";
    request(1'b0); cyc(2);
    spot("R7", 1'b0, 1'b0);

    // R2 mode 0 entry
    start_hi = 0; tag = "R2";
    request(1'b0); cyc(1);
    spot("R2", 1'b1, 1'b0);
    // R7: second request while powered down keeps mode 0
    tag = "R7"; request(1'b1); cyc(2);
    spot("R7", 1'b1, 1'b0);

    // R4: analog channel (enabled) and digital disabled channels
    tag = "R4";
    ch_in[1] = ~ch_in[1]; cyc(5);
    ch_in[0] = ~ch_in[0]; ch_in[7] = ~ch_in[7]; ch_in[6] = ~ch_in[6]; cyc(6);
    spot("R4", 1'b1, 1'b0);

    // R3: qualifying toggle, flip three edges later
    tag = "R3";
    ch_in[3] = ~ch_in[3];
    cyc(2); spot("R3", 1'b1, 1'b0);
    cyc(1); spot("R3", 1'b1, 1'b1);

    // R5: hold after flip
    tag = "R5";
    ch_in[3] = ~ch_in[3]; cyc(4);
    ch_in[5:2] = ~ch_in[5:2]; cyc(6);
    spot("R5", 1'b1, 1'b1);

    // R6: release
    tag = "R6";
    start_hi = 1; cyc(1);
    spot("R6", 1'b0, 1'b0);
    cyc(3);

    // R9: change before entry does not trigger, returning does
    tag = "R9";
    ch_in[4] = ~ch_in[4]; cyc(5);
    start_hi = 0;
    request(1'b1); cyc(1);
    spot("R2", 1'b1, 1'b1);
    cyc(8); spot("R9", 1'b1, 1'b1);
    ch_in[4] = ~ch_in[4];
    cyc(3); spot("R9", 1'b1, 1'b0);
    tag = "R5"; ch_in = ~ch_in; cyc(6);
    spot("R5", 1'b1, 1'b0);
    tag = "R6"; start_hi = 1; cyc(1);
    spot("R6", 1'b0, 1'b0);
    cyc(3);

    // R8: nothing qualifies
    tag = "R8";
    wake_en = 8'b0000_0011;       // only analog channels enabled
    start_hi = 0;
    request(1'b1);
    for (int i = 0; i < 20; i++) begin ch_in = ch_in ^ 8'(i * 37 + 1); cyc(3); end
    spot("R8", 1'b1, 1'b1);
    start_hi = 1; cyc(1);
    spot("R6", 1'b0, 1'b0);
    cyc(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule